// File: doc/BRIEF.md
# Illegal Instruction Classifier

This block sits next to an instruction decode stage. For each instruction being decoded it decides whether a general illegal-instruction exception must be raised. It reports why with a small reason code. It looks at the raw 16-bit opcode and at class flags already produced by the decoder. The flags say whether the instruction is privileged, whether it is a DSP-type operation, and which of the program counter, the status register and the repeat-start or repeat-end register it writes. It also looks at the delay-slot indicator, the current mode, the DSP-enable bit and the position inside an active hardware repeat loop.

Four conditions are checked: an undefined opcode, a privileged instruction in user mode, a DSP instruction while DSP is disabled, and a control- or loop-register write among the final instructions of a repeat loop. Instructions in a delay slot are never flagged here, because another exception path handles them.

The verdict is available combinationally for the decoder. A registered copy, aligned with the decode-valid strobe, is available for the exception logic one stage later.

Top module: `illop_classifier`

## Requirements
- R1: An opcode whose bits [15:12] equal 4'hF, outside a delay slot, sets `illegal_o` with reason 1 (undefined).
- R2: An instruction with `cls_priv_i`=1 decoded while `user_mode_i`=1, outside a delay slot, is illegal with reason 2 (privileged).
- R3: The global-base-register control forms are not privileged, whatever `cls_priv_i` says, and never produce reason 2. They are load from register (4'h4,m,8'h1E), load post-increment (4'h4,m,8'h17), store to register (4'h0,n,8'h12) and store pre-decrement (4'h4,n,8'h13), with the nibble order being bits [15:12], [11:8], [7:0].
- R4: An instruction with `cls_dsp_i`=1 while `dsp_en_i`=0, outside a delay slot, is illegal with reason 3 (DSP disabled).
- R5: When `rpt_active_i`=1 and 1 <= `rpt_left_i` <= 3, any instruction that writes the PC, status, repeat-start or repeat-end register is illegal with reason 4 (loop tail). Here `rpt_left_i` counts the instructions left in the loop body including the current one, so 1 is the last. It is legal when `rpt_left_i` is 0 or above 3, or when the loop is inactive.
- R6: The status-load opcodes count as both a PC write and a status write for R5, even if the class flags are clear. They are (4'h4,m,8'h0E) and (4'h4,m,8'h07).
- R7: While `in_dslot_i`=1, `illegal_o` is 0 and `reason_o` is 0.
- R8: When several conditions hold, the reason follows the priority undefined (1) > privileged (2) > DSP disabled (3) > loop tail (4).
- R9: When no condition holds, `illegal_o` is 0 and `reason_o` is 0. `illegal_o` is 1 exactly when `reason_o` is non-zero.
- R10: After each rising edge, `out_valid_o` equals the `dec_valid_i` sampled at that edge. `illegal_q_o` and `reason_q_o` then hold the combinational verdict of that cycle when it was valid, and 0 otherwise. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | A decoded instruction is present this cycle |
| opcode_i | input | 16 | Instruction word |
| cls_priv_i | input | 1 | Predecoded: privileged class |
| cls_dsp_i | input | 1 | Predecoded: DSP class |
| cls_wr_pc_i | input | 1 | Predecoded: writes the program counter |
| cls_wr_sr_i | input | 1 | Predecoded: writes the status register |
| cls_wr_rs_i | input | 1 | Predecoded: writes the repeat-start register |
| cls_wr_re_i | input | 1 | Predecoded: writes the repeat-end register |
| in_dslot_i | input | 1 | Instruction sits in a delay slot |
| user_mode_i | input | 1 | 1 = user mode, 0 = privileged mode |
| dsp_en_i | input | 1 | Status DSP-enable bit |
| rpt_active_i | input | 1 | A hardware repeat loop is running |
| rpt_left_i | input | CNT_W | Instructions left in the loop body, current included |
| illegal_o | output | 1 | Combinational illegal verdict |
| reason_o | output | 3 | Combinational reason code (0 none, 1..4 as in R1, R2, R4, R5) |
| out_valid_o | output | 1 | Registered decode-valid |
| illegal_q_o | output | 1 | Registered illegal verdict |
| reason_q_o | output | 3 | Registered reason code |

## Verification
The assertions take for granted that the class flags are stable and defined throughout each clock cycle. They also assume that `rpt_left_i` is meaningful only while `rpt_active_i` is high, so that the loop-tail check is gated by the active bit alone. The stimulus is changed only at falling edges, so every input stays constant around the rising edge. The vector table sets `rpt_active_i` explicitly in every entry, covering both the active and the inactive case with non-zero counts.

// File: rtl/illop_pkg.sv
package illop_pkg;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_UNDEF    = 3'd1,
        RSN_PRIV     = 3'd2,
        RSN_DSPOFF   = 3'd3,
        RSN_LOOPTAIL = 3'd4
    } reason_e;

    localparam int NUM_COND = 4;

    typedef struct packed {
        logic       vld;
        logic       ill;
        logic [2:0] rsn;
    } outreg_t;

endpackage

// File: rtl/illop_opmatch.sv
module illop_opmatch (
    input  logic [15:0] opcode_i,
    output logic        is_undef_o,
    output logic        is_gbr_ctl_o,
    output logic        is_sr_load_o
);
    logic [3:0] top_nib;
    logic [7:0] low_byte;
    logic       unused_regfield;

    assign top_nib         = opcode_i[15:12];
    assign low_byte        = opcode_i[7:0];
    assign unused_regfield = ^opcode_i[11:8];

    always_comb begin
        is_undef_o   = (top_nib == 4'hF);
        is_gbr_ctl_o = ((top_nib == 4'h4) &&
                        ((low_byte == 8'h1E) || (low_byte == 8'h17) || (low_byte == 8'h13))) ||
                       ((top_nib == 4'h0) && (low_byte == 8'h12));
        is_sr_load_o = (top_nib == 4'h4) &&
                       ((low_byte == 8'h0E) || (low_byte == 8'h07));
    end
endmodule

// File: rtl/illop_prio.sv
module illop_prio
    import illop_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic [N-1:0] cond_i,
    output logic         any_o,
    output logic [2:0]   code_o
);
    always_comb begin
        code_o = 3'd0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cond_i[i]) begin
                code_o = 3'(i + 1);
            end
        end
        any_o = |cond_i;
    end
endmodule

// File: rtl/illop_classifier.sv
module illop_classifier
    import illop_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TAIL_LEN = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dec_valid_i,
    input  logic [15:0]      opcode_i,
    input  logic             cls_priv_i,
    input  logic             cls_dsp_i,
    input  logic             cls_wr_pc_i,
    input  logic             cls_wr_sr_i,
    input  logic             cls_wr_rs_i,
    input  logic             cls_wr_re_i,
    input  logic             in_dslot_i,
    input  logic             user_mode_i,
    input  logic             dsp_en_i,
    input  logic             rpt_active_i,
    input  logic [CNT_W-1:0] rpt_left_i,
    output logic             illegal_o,
    output logic [2:0]       reason_o,
    output logic             out_valid_o,
    output logic             illegal_q_o,
    output logic [2:0]       reason_q_o
);
    localparam logic [CNT_W-1:0] TAIL_MAX = CNT_W'(TAIL_LEN);

    logic                is_undef, is_gbr_ctl, is_sr_load;
    logic                in_tail, writes_ctl;
    logic [NUM_COND-1:0] cond;
    logic                any_cond;
    logic [2:0]          code;
    outreg_t             out_d, out_q;

    illop_opmatch u_match (
        .opcode_i     (opcode_i),
        .is_undef_o   (is_undef),
        .is_gbr_ctl_o (is_gbr_ctl),
        .is_sr_load_o (is_sr_load)
    );

    always_comb begin
        in_tail    = rpt_active_i && (rpt_left_i != '0) && (rpt_left_i <= TAIL_MAX);
        writes_ctl = cls_wr_pc_i || cls_wr_sr_i || cls_wr_rs_i || cls_wr_re_i || is_sr_load;
        cond       = '0;
        if (!in_dslot_i) begin
            cond[0] = is_undef;
            cond[1] = cls_priv_i && user_mode_i && !is_gbr_ctl;
            cond[2] = cls_dsp_i && !dsp_en_i;
            cond[3] = in_tail && writes_ctl;
        end
    end

    illop_prio #(.N(NUM_COND)) u_prio (
        .cond_i (cond),
        .any_o  (any_cond),
        .code_o (code)
    );

    assign illegal_o = any_cond;
    assign reason_o  = code;

    always_comb begin
        out_d     = '0;
        out_d.vld = dec_valid_i;
        if (dec_valid_i) begin
            out_d.ill = any_cond;
            out_d.rsn = code;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o = out_q.vld;
    assign illegal_q_o = out_q.ill;
    assign reason_q_o  = out_q.rsn;
endmodule

// File: rtl/illop_classifier_chk.sv
module illop_classifier_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        dec_valid_i,
    input logic [15:0] opcode_i,
    input logic        cls_priv_i,
    input logic        in_dslot_i,
    input logic        user_mode_i,
    input logic        illegal_o,
    input logic [2:0]  reason_o,
    input logic        out_valid_o,
    input logic        illegal_q_o,
    input logic [2:0]  reason_q_o
);
    logic gbr_form;
    assign gbr_form = ((opcode_i[15:12] == 4'h4) &&
                       (opcode_i[7:0] == 8'h1E || opcode_i[7:0] == 8'h17 || opcode_i[7:0] == 8'h13)) ||
                      ((opcode_i[15:12] == 4'h0) && (opcode_i[7:0] == 8'h12));

    // R1
    undef_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_dslot_i && opcode_i[15:12] == 4'hF) |-> (illegal_o && reason_o == 3'd1));

    // R2
    priv_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_dslot_i && opcode_i[15:12] != 4'hF && cls_priv_i && user_mode_i && !gbr_form)
            |-> (reason_o == 3'd2));

    // R3
    gbr_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gbr_form |-> (reason_o != 3'd2));

    // R7
    dslot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_dslot_i |-> (!illegal_o && reason_o == 3'd0));

    // R9
    flag_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o == (reason_o != 3'd0));

    // R10
    valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |=> (out_valid_o && illegal_q_o == $past(illegal_o) && reason_q_o == $past(reason_o)));

    // R10
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_valid_i |=> (!out_valid_o && !illegal_q_o && reason_q_o == 3'd0));
endmodule

bind illop_classifier illop_classifier_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid_i),
    .opcode_i    (opcode_i),
    .cls_priv_i  (cls_priv_i),
    .in_dslot_i  (in_dslot_i),
    .user_mode_i (user_mode_i),
    .illegal_o   (illegal_o),
    .reason_o    (reason_o),
    .out_valid_o (out_valid_o),
    .illegal_q_o (illegal_q_o),
    .reason_q_o  (reason_q_o)
);

// File: tb/tb_illop_classifier.sv
`timescale 1ns/1ps
module tb_illop_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dv = 1'b0;
    logic [15:0] op = 16'h0;
    logic        priv = 0, dsp = 0, wpc = 0, wsr = 0, wrs = 0, wre = 0;
    logic        dslot = 0, user = 0, dspen = 0, ract = 0;
    logic [7:0]  left = 8'd0;
    logic        ill, ill_q, vld_q;
    logic [2:0]  rsn, rsn_q;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    illop_classifier dut (
        .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv), .opcode_i(op),
        .cls_priv_i(priv), .cls_dsp_i(dsp), .cls_wr_pc_i(wpc), .cls_wr_sr_i(wsr),
        .cls_wr_rs_i(wrs), .cls_wr_re_i(wre), .in_dslot_i(dslot), .user_mode_i(user),
        .dsp_en_i(dspen), .rpt_active_i(ract), .rpt_left_i(left),
        .illegal_o(ill), .reason_o(rsn), .out_valid_o(vld_q),
        .illegal_q_o(ill_q), .reason_q_o(rsn_q)
    );

    // flags order: priv dsp wpc wsr wrs wre dslot user dspen ract
    function automatic logic [36:0] mk(logic [15:0] o, logic [9:0] f, logic [7:0] l, logic [2:0] e);
        return {o, f, l, e};
    endfunction

    localparam int NV = 24;
    localparam logic [36:0] VEC [NV] = '{
        mk(16'h6003, 10'b0000000110, 8'd0, 3'd0), // R9 plain
        mk(16'hF123, 10'b0000000010, 8'd0, 3'd1), // R1
        mk(16'hF123, 10'b0000001010, 8'd0, 3'd0), // R7
        mk(16'h0002, 10'b1000000110, 8'd0, 3'd2), // R2
        mk(16'h0002, 10'b1000000010, 8'd0, 3'd0), // R2 supervisor
        mk(16'h411E, 10'b1000000110, 8'd0, 3'd0), // R3
        mk(16'h0112, 10'b1000000110, 8'd0, 3'd0), // R3
        mk(16'h4117, 10'b1000000110, 8'd0, 3'd0), // R3
        mk(16'h4113, 10'b1000000110, 8'd0, 3'd0), // R3
        mk(16'h406A, 10'b0100000100, 8'd0, 3'd3), // R4
        mk(16'h406A, 10'b0100000110, 8'd0, 3'd0), // R4 enabled
        mk(16'h402B, 10'b0010000011, 8'd3, 3'd4), // R5 edge 3
        mk(16'h402B, 10'b0010000011, 8'd4, 3'd0), // R5 outside
        mk(16'h4A1D, 10'b0000010011, 8'd1, 3'd4), // R5 last
        mk(16'h4A1D, 10'b0000010011, 8'd0, 3'd0), // R5 zero
        mk(16'h420E, 10'b1000000011, 8'd2, 3'd4), // R6
        mk(16'h420E, 10'b1000000010, 8'd2, 3'd0), // R6 loop off
        mk(16'h4307, 10'b1000000011, 8'd1, 3'd4), // R6
        mk(16'hF000, 10'b1100000100, 8'd0, 3'd1), // R8
        mk(16'h4000, 10'b1110000101, 8'd2, 3'd2), // R8
        mk(16'h4000, 10'b0100100101, 8'd3, 3'd3), // R8
        mk(16'h402B, 10'b0010001011, 8'd3, 3'd0), // R7
        mk(16'h4000, 10'b0001000011, 8'd3, 3'd4), // R5 status
        mk(16'h4000, 10'b0000000011, 8'd3, 3'd0)  // R9
    };

    function automatic string tag_of(logic [2:0] e);
        case (e)
            3'd1: return "R1/R8";
            3'd2: return "R2/R8";
            3'd3: return "R4/R8";
            3'd4: return "R5/R6";
            default: return "R3/R7/R9";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [36:0] v);
        op = v[36:21];
        {priv, dsp, wpc, wsr, wrs, wre, dslot, user, dspen, ract} = v[20:11];
        left = v[10:3];
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset", {vld_q, ill_q, rsn_q[1:0]}, 4'b0);
        check("R10 reset code", {1'b0, rsn_q}, 4'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            dv = 1'b1;
            #1;
            check(tag_of(VEC[i][2:0]), {ill, rsn}, {(VEC[i][2:0] != 3'd0), VEC[i][2:0]});
            @(posedge clk);
            #1;
            check("R10 reg", {ill_q, rsn_q}, {(VEC[i][2:0] != 3'd0), VEC[i][2:0]});
            check("R10 valid", {3'b0, vld_q}, 4'd1);
        end
        // R10: illegal input but no valid strobe leaves registered outputs clear
        @(negedge clk);
        drive(VEC[1]);
        dv = 1'b0;
        @(posedge clk);
        #1;
        check("R10 idle", {vld_q, ill_q, rsn_q[1:0]}, 4'b0);
        check("R1 comb while idle", {ill, rsn}, 4'b1001);
        // R10: reset in the middle clears registered copy
        @(negedge clk);
        dv = 1'b1;
        @(posedge clk);
        #1;
        check("R10 before reset", {ill_q, rsn_q}, 4'b1001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async reset", {vld_q, ill_q, rsn_q[1:0]}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule